// File: doc/BRIEF.md
# Flash Embedded Operation Status Controller

This block is the sequencing core of a single-supply NOR flash. It takes program, sector-erase, chip-erase, suspend and resume requests that an upstream command decoder has already decoded, and runs each one as a timed embedded operation on a small on-chip byte array. The array is split into eleven sectors whose sizes follow a 2:1:1:4:8×7 ratio. A parameter sets the number of bytes in one size unit. A second parameter places the small sectors at the top or at the bottom of the address space.

While an operation runs, an array read returns a status byte instead of cell data. This lets a host poll for completion. A data-polling bit reports the complement of the expected bit 7. A busy-toggle bit flips on every status read. An erase-toggle bit flips only when the read targets a sector that is part of the current erase. An erase can be suspended so the host can read or program sectors that are not being erased, and then resumed.

A per-sector protection mask makes protected sectors ignore both program and erase. A synchronous reset aborts any operation and returns the block to plain array reads.

Top module: `flash_op_ctrl`

## Requirements
- R1: After reset, `busy` and `suspended` are 0 and every byte reads 0xFF. Read data appears on `rdata` in the cycle after the clock edge that samples `rd_en`.
- R2: A program request (cmd_op 1) to an unprotected sector raises `busy` from the next cycle until the operation completes. The addressed byte then holds its old value AND the request data, so bits can only go from 1 to 0.
- R3: During a running program, status bit 7 equals the complement of bit 7 of the requested data. During a running erase it is 0. After completion, reads return true array data.
- R4: Bit 6 of successive status reads alternates, both during a running operation and when reading an erase-selected sector while suspended.
- R5: Bit 2 of successive status reads alternates only when the read address lies in a sector selected for the current erase. Otherwise it holds its value.
- R6: A sector erase (cmd_op 2, sector bit i of `erase_sel` picks sector i in address order) runs three timed phases in order: preprogram, erase, verify. Afterwards every byte of each selected sector is 0xFF and all other sectors are unchanged.
- R7: A chip erase (cmd_op 3) sets every byte of every unprotected sector to 0xFF and leaves protected sectors unchanged.
- R8: A sector whose `prot_mask` bit is set ignores program requests and is dropped from an erase. If no selected sector remains unprotected, the erase is ignored and `busy` stays 0.
- R9: A suspend (cmd_op 4) during an erase raises `suspended` and drops `busy` in the next cycle. While suspended, non-selected sectors read as array data. Selected sectors read as status with bit 7 = 1. A program to an unprotected non-selected sector runs and then returns to suspended. A program to a selected sector is ignored.
- R10: A resume (cmd_op 5) while suspended raises `busy` and continues the interrupted erase to completion, keeping any data programmed during the suspension.
- R11: Asserting `rst` during any operation or suspension drops `busy` and `suspended` in the next cycle.
- R12: With TOP_BOOT = 0, sector 0 is the 2-unit sector at address 0 and sector 10 is a 8-unit sector at the top. With TOP_BOOT = 1, the order is mirrored: sector 10 is the 2-unit sector at the highest addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, aborts any operation |
| cmd_valid | input | 1 | Request strobe, one cycle per request |
| cmd_op | input | 3 | Request code: 1 program, 2 sector erase, 3 chip erase, 4 suspend, 5 resume |
| cmd_addr | input | AW | Byte address for a program request |
| cmd_data | input | 8 | Data for a program request |
| erase_sel | input | 11 | Sectors to erase for a sector-erase request |
| prot_mask | input | 11 | Per-sector protection, 1 = protected |
| rd_en | input | 1 | Array read strobe |
| rd_addr | input | AW | Read byte address |
| rdata | output | 8 | Read data or status byte, registered |
| busy | output | 1 | An embedded operation is running |
| suspended | output | 1 | An erase is on hold |

## Verification
The bench targets protected sectors hit by program and erase requests. A design that ignored protection would start an operation and alter bytes that must stay intact. It also runs an erase whose whole selection is protected; a design that got this wrong would report busy for an erase with nothing to do. During suspension, the bench reads and programs both a selected and a non-selected sector. A wrong design would either leak status onto healthy sectors or let a program corrupt a half-erased sector. The toggle bits are read in back-to-back pairs on erasing and non-erasing sectors to catch a bit 2 that toggles everywhere. A mirrored-boot instance catches a sector map that ignores the boot ordering.

// File: rtl/fopc_pkg.sv
package fopc_pkg;

    localparam int NSEC  = 11;
    localparam int UNITS = 64;

    typedef logic [NSEC-1:0] secmask_t;
    typedef logic [3:0]      secidx_t;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_SERASE = 3'd2,
        OP_CERASE = 3'd3,
        OP_SUSP   = 3'd4,
        OP_RESUME = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_PRE,
        ST_ERASE,
        ST_VERIFY,
        ST_SUSP
    } state_e;

    typedef struct packed {
        logic       poll;
        logic       tog_busy;
        logic [2:0] rsv_hi;
        logic       tog_erase;
        logic [1:0] rsv_lo;
    } stat_t;

    // sector index of a size unit with the small sectors at the low end
    function automatic secidx_t low_boot_sector(int unsigned u);
        if (u < 2)      return secidx_t'(0);
        else if (u < 3) return secidx_t'(1);
        else if (u < 4) return secidx_t'(2);
        else if (u < 8) return secidx_t'(3);
        else            return secidx_t'(4 + (u - 8) / 8);
    endfunction

    function automatic secidx_t unit_sector(int unsigned u, bit top);
        if (top) return secidx_t'(NSEC - 1 - int'(low_boot_sector(UNITS - 1 - u)));
        else     return low_boot_sector(u);
    endfunction

    function automatic bit op_running(state_e s);
        return (s == ST_PROG) || (s == ST_PRE) || (s == ST_ERASE) || (s == ST_VERIFY);
    endfunction

endpackage

// File: rtl/flash_sector_map.sv
module flash_sector_map
    import fopc_pkg::*;
#(
    parameter int UNIT_BYTES = 2,
    parameter bit TOP_BOOT   = 1'b0,
    parameter int AW         = 7
) (
    input  logic [AW-1:0] addr,
    output secidx_t       sec
);

    int unsigned unit_idx;
    assign unit_idx = int'(addr) / UNIT_BYTES;

    generate
        if (TOP_BOOT) begin : g_top
            assign sec = unit_sector(unit_idx, 1'b1);
        end else begin : g_bottom
            assign sec = low_boot_sector(unit_idx);
        end
    endgenerate

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
    import fopc_pkg::*;
#(
    parameter int UNIT_BYTES = 2,
    parameter bit TOP_BOOT   = 1'b0,
    parameter int DEPTH      = 128,
    parameter int AW         = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prog_we,
    input  logic [AW-1:0] prog_addr,
    input  logic [7:0]    prog_data,
    input  logic          fill_en,
    input  logic [7:0]    fill_val,
    input  secmask_t      fill_mask,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        localparam secidx_t SEC = unit_sector(i / UNIT_BYTES, TOP_BOOT);
        logic [7:0] val;
        logic       hit;

        assign hit = prog_we && (int'(prog_addr) == i);

        always_ff @(posedge clk) begin
            if (rst) begin
                val <= 8'hFF;
            end else if (fill_en && fill_mask[SEC]) begin
                val <= fill_val;
            end else if (hit) begin
                val <= val & prog_data;
            end
        end

        assign cells[i] = val;

        // programming never turns a 0 bit back into 1
        assert_prog_clears_only_R2: assert property (@(posedge clk) disable iff (rst)
            (hit && !fill_en) |=> ((val & ~$past(val)) == 8'h00));
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
    import fopc_pkg::*;
#(
    parameter int PROG_CYCLES   = 4,
    parameter int PRE_CYCLES    = 16,
    parameter int ERASE_CYCLES  = 64,
    parameter int VERIFY_CYCLES = 8,
    parameter int AW            = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  op_e           cmd_op,
    input  secidx_t       cmd_sec,
    input  logic [AW-1:0] cmd_addr,
    input  logic [7:0]    cmd_data,
    input  secmask_t      erase_sel,
    input  secmask_t      prot_mask,
    output state_e        state,
    output secmask_t      sel_mask,
    output logic [AW-1:0] lat_addr,
    output logic [7:0]    lat_data,
    output logic          prog_we,
    output logic          fill_en,
    output logic [7:0]    fill_val
);

    localparam int MAX_AB = (PROG_CYCLES > PRE_CYCLES) ? PROG_CYCLES : PRE_CYCLES;
    localparam int MAX_CD = (ERASE_CYCLES > VERIFY_CYCLES) ? ERASE_CYCLES : VERIFY_CYCLES;
    localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CW     = $clog2(MAXC + 1);

    logic [CW-1:0] cnt, saved_cnt;
    state_e        saved_state;
    logic          ret_susp;
    secmask_t      new_mask;
    logic          susp_req, cnt_done, prog_ok;

    always_comb begin
        new_mask = ((cmd_op == OP_CERASE) ? {NSEC{1'b1}} : erase_sel) & ~prot_mask;
        susp_req = cmd_valid && (cmd_op == OP_SUSP);
        cnt_done = (cnt == '0);
        prog_ok  = cmd_valid && (cmd_op == OP_PROG) && !prot_mask[cmd_sec];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            saved_cnt   <= '0;
            saved_state <= ST_IDLE;
            sel_mask    <= '0;
            ret_susp    <= 1'b0;
            lat_addr    <= '0;
            lat_data    <= 8'h00;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (prog_ok) begin
                        state    <= ST_PROG;
                        cnt      <= CW'(PROG_CYCLES - 1);
                        lat_addr <= cmd_addr;
                        lat_data <= cmd_data;
                        ret_susp <= 1'b0;
                    end else if (cmd_valid && (cmd_op == OP_SERASE || cmd_op == OP_CERASE)
                                 && (new_mask != '0)) begin
                        state    <= ST_PRE;
                        cnt      <= CW'(PRE_CYCLES - 1);
                        sel_mask <= new_mask;
                    end
                end
                ST_PROG: begin
                    if (cnt_done) state <= ret_susp ? ST_SUSP : ST_IDLE;
                    else          cnt   <= cnt - 1'b1;
                end
                ST_PRE, ST_ERASE, ST_VERIFY: begin
                    if (susp_req) begin
                        saved_state <= state;
                        saved_cnt   <= cnt;
                        state       <= ST_SUSP;
                    end else if (cnt_done) begin
                        if (state == ST_PRE) begin
                            state <= ST_ERASE;
                            cnt   <= CW'(ERASE_CYCLES - 1);
                        end else if (state == ST_ERASE) begin
                            state <= ST_VERIFY;
                            cnt   <= CW'(VERIFY_CYCLES - 1);
                        end else begin
                            state    <= ST_IDLE;
                            sel_mask <= '0;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_SUSP: begin
                    if (cmd_valid && cmd_op == OP_RESUME) begin
                        state <= saved_state;
                        cnt   <= saved_cnt;
                    end else if (prog_ok && !sel_mask[cmd_sec]) begin
                        state    <= ST_PROG;
                        cnt      <= CW'(PROG_CYCLES - 1);
                        lat_addr <= cmd_addr;
                        lat_data <= cmd_data;
                        ret_susp <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign prog_we  = (state == ST_PROG) && cnt_done;
    assign fill_en  = cnt_done && !susp_req && (state == ST_PRE || state == ST_ERASE);
    assign fill_val = (state == ST_PRE) ? 8'h00 : 8'hFF;

    assert_prot_prog_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && cmd_valid && cmd_op == OP_PROG && prot_mask[cmd_sec])
        |=> (state == ST_IDLE));

    assert_susp_has_sel_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SUSP) |-> (sel_mask != '0));

    assert_susp_prog_sel_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SUSP && cmd_valid && cmd_op == OP_PROG && sel_mask[cmd_sec])
        |=> (state == ST_SUSP));

    assert_resume_to_erase_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SUSP && cmd_valid && cmd_op == OP_RESUME)
        |=> (state == ST_PRE || state == ST_ERASE || state == ST_VERIFY));

    assert_erase_after_pre_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ERASE && $past(state) != ST_ERASE)
        |-> ($past(state) == ST_PRE || $past(state) == ST_SUSP));

endmodule

// File: rtl/flash_status_read.sv
module flash_status_read
    import fopc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_en,
    input  secidx_t    rd_sec,
    input  logic [7:0] cell_data,
    input  state_e     state,
    input  secmask_t   sel_mask,
    input  logic [7:0] lat_data,
    output logic [7:0] rdata
);

    logic  t_busy, t_erase, show_stat, in_sel;
    stat_t stat;

    always_comb begin
        in_sel         = sel_mask[rd_sec];
        show_stat      = op_running(state) || (state == ST_SUSP && in_sel);
        stat           = '0;
        stat.poll      = (state == ST_PROG) ? ~lat_data[7] : (state == ST_SUSP);
        stat.tog_busy  = t_busy;
        stat.tog_erase = t_erase;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata   <= 8'h00;
            t_busy  <= 1'b0;
            t_erase <= 1'b0;
        end else if (rd_en) begin
            if (show_stat) begin
                rdata  <= stat;
                t_busy <= ~t_busy;
                if (in_sel) t_erase <= ~t_erase;
            end else begin
                rdata <= cell_data;
            end
        end
    end

    assert_busy_toggle_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && show_stat) ##1 (rd_en && show_stat) |=> (rdata[6] != $past(rdata[6])));

    assert_erase_toggle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && show_stat && !in_sel) ##1 (rd_en && show_stat) |=> (rdata[2] == $past(rdata[2])));

endmodule

// File: rtl/flash_op_ctrl.sv
module flash_op_ctrl
    import fopc_pkg::*;
#(
    parameter int UNIT_BYTES    = 2,
    parameter bit TOP_BOOT      = 1'b0,
    parameter int PROG_CYCLES   = 4,
    parameter int PRE_CYCLES    = 16,
    parameter int ERASE_CYCLES  = 64,
    parameter int VERIFY_CYCLES = 8,
    localparam int DEPTH        = UNITS * UNIT_BYTES,
    localparam int AW           = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [7:0]    cmd_data,
    input  logic [10:0]   erase_sel,
    input  logic [10:0]   prot_mask,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rdata,
    output logic          busy,
    output logic          suspended
);

    secidx_t       cmd_sec, rd_sec;
    state_e        state;
    secmask_t      sel_mask;
    logic [AW-1:0] lat_addr;
    logic [7:0]    lat_data, fill_val, cell_data;
    logic          prog_we, fill_en;

    flash_sector_map #(.UNIT_BYTES(UNIT_BYTES), .TOP_BOOT(TOP_BOOT), .AW(AW)) u_cmd_map (
        .addr(cmd_addr), .sec(cmd_sec)
    );

    flash_sector_map #(.UNIT_BYTES(UNIT_BYTES), .TOP_BOOT(TOP_BOOT), .AW(AW)) u_rd_map (
        .addr(rd_addr), .sec(rd_sec)
    );

    flash_op_seq #(
        .PROG_CYCLES(PROG_CYCLES), .PRE_CYCLES(PRE_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES), .VERIFY_CYCLES(VERIFY_CYCLES), .AW(AW)
    ) u_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(op_e'(cmd_op)),
        .cmd_sec(cmd_sec), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .erase_sel(erase_sel), .prot_mask(prot_mask), .state(state),
        .sel_mask(sel_mask), .lat_addr(lat_addr), .lat_data(lat_data),
        .prog_we(prog_we), .fill_en(fill_en), .fill_val(fill_val)
    );

    flash_cell_array #(.UNIT_BYTES(UNIT_BYTES), .TOP_BOOT(TOP_BOOT), .DEPTH(DEPTH), .AW(AW)) u_array (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(lat_addr),
        .prog_data(lat_data), .fill_en(fill_en), .fill_val(fill_val),
        .fill_mask(sel_mask), .rd_addr(rd_addr), .rd_data(cell_data)
    );

    flash_status_read u_status (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sec(rd_sec),
        .cell_data(cell_data), .state(state), .sel_mask(sel_mask),
        .lat_data(lat_data), .rdata(rdata)
    );

    assign busy      = op_running(state);
    assign suspended = (state == ST_SUSP);

    assert_reset_idle_R11: assert property (@(posedge clk)
        rst |=> (!busy && !suspended));

endmodule

// File: tb/flash_op_ctrl_bench.sv
module flash_op_ctrl_bench;

    localparam int DEPTH = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [6:0]  cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic [10:0] erase_sel = '0;
    logic [10:0] prot_mask = '0;
    logic        rd_en = 1'b0;
    logic [6:0]  rd_addr = '0;
    logic [7:0]  rdata, rdata2;
    logic        busy, busy2, suspended, suspended2;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    int unsigned cyc = 0;
    bit          done = 1'b0;
    logic [7:0]  model [DEPTH];

    always #2.5 clk = ~clk;

    flash_op_ctrl u_flash_op_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .erase_sel(erase_sel),
        .prot_mask(prot_mask), .rd_en(rd_en), .rd_addr(rd_addr),
        .rdata(rdata), .busy(busy), .suspended(suspended)
    );

    flash_op_ctrl #(.TOP_BOOT(1'b1)) u_flash_op_ctrl_topboot (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .erase_sel(erase_sel),
        .prot_mask(prot_mask), .rd_en(rd_en), .rd_addr(rd_addr),
        .rdata(rdata2), .busy(busy2), .suspended(suspended2)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    function automatic int sec_of(int a, bit top);
        int sz [11] = '{2, 1, 1, 4, 8, 8, 8, 8, 8, 8, 8};
        int base = 0;
        for (int k = 0; k < 11; k++) begin
            int s = top ? sz[10-k] : sz[k];
            if (a / 2 < base + s) return k;
            base += s;
        end
        return -1;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_cmd(int op, int a, int d, logic [10:0] sel);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = 7'(a);
        cmd_data = 8'(d); erase_sel = sel;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic rd(int a, output logic [7:0] v, output logic [7:0] v2);
        rd_en = 1'b1; rd_addr = 7'(a);
        @(negedge clk);
        v = rdata; v2 = rdata2;
        rd_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            if (!busy && !busy2) break;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    endtask

    task automatic check_all(string tag);
        logic [7:0] v, v2;
        int nbad_local = 0;
        for (int i = 0; i < DEPTH; i++) begin
            rd(i, v, v2);
            if (v != model[i]) begin
                nbad_local++;
                chk(1'b0, tag, v, model[i]);
            end
        end
        if (nbad_local == 0) chk(1'b1, tag, 0, 0);
    endtask

    initial begin
        logic [7:0] a, b, a2, b2;
        int addr, data;
        void'($urandom(32'h5EED_0042));
        do_reset();

        // R1 reset state
        chk(!busy && !suspended, "R1 idle after reset", {busy, suspended}, 0);
        rd(5, a, a2);
        chk(a == 8'hFF, "R1 erased after reset", a, 8'hFF);

        // R2/R3/R4/R5 directed program
        do_cmd(1, 10, 8'h5A, '0);
        chk(busy == 1'b1, "R2 busy during program", busy, 1);
        rd(10, a, a2); rd(10, b, b2);
        chk(a[7] == 1'b1, "R3 poll bit is complement", a[7], 1);
        chk(a[6] != b[6], "R4 busy toggle", b[6], !a[6]);
        chk(a[2] == b[2], "R5 no erase toggle outside erase", b[2], a[2]);
        wait_idle();
        model[10] &= 8'h5A;
        rd(10, a, a2);
        chk(a == 8'h5A, "R3 true data after program", a, 8'h5A);
        do_cmd(1, 10, 8'h0F, '0);
        wait_idle();
        model[10] &= 8'h0F;
        rd(10, a, a2);
        chk(a == 8'h0A, "R2 program only clears bits", a, 8'h0A);

        // R2/R8 random programs under random protection
        for (int it = 0; it < 40; it++) begin
            bit prot;
            addr = int'($urandom_range(0, DEPTH - 1));
            data = int'($urandom_range(0, 255));
            prot_mask = 11'($urandom_range(0, 2047));
            prot = prot_mask[sec_of(addr, 1'b0)];
            do_cmd(1, addr, data, '0);
            chk(busy == !prot, prot ? "R8 protected program ignored" : "R2 program starts",
                busy, !prot);
            wait_idle();
            if (!prot) model[addr] &= 8'(data);
            rd(addr, a, a2);
            chk(a == model[addr], "R2 random program result", a, model[addr]);
        end
        prot_mask = '0;

        // R6/R8/R3/R5 sector erase with one protected sector
        do_cmd(1, 4, 8'h00, '0); model[4] = 8'h00;
        wait_idle();
        prot_mask = 11'b000_0010_0000;
        do_cmd(2, 0, 0, 11'b000_0010_0010);
        chk(busy == 1'b1, "R6 erase started", busy, 1);
        rd(4, a, a2); rd(4, b, b2);
        chk(a[7] == 1'b0, "R3 poll bit during erase", a[7], 0);
        chk(a[2] != b[2], "R5 erase toggle on selected sector", b[2], !a[2]);
        rd(40, a, a2); rd(40, b, b2);
        chk(a[2] == b[2], "R5 no erase toggle on other sector", b[2], a[2]);
        chk(a[6] != b[6], "R4 busy toggle during erase", b[6], !a[6]);
        wait_idle();
        for (int i = 0; i < DEPTH; i++) if (sec_of(i, 1'b0) == 1) model[i] = 8'hFF;
        check_all("R6 sector erase result");

        // R8 erase of only protected sectors is ignored
        do_cmd(2, 0, 0, 11'b000_0010_0000);
        chk(busy == 1'b0, "R8 fully protected erase ignored", busy, 0);
        prot_mask = '0;

        // R9/R10 suspend, program elsewhere, resume
        do_cmd(1, 20, 8'h00, '0); model[20] = 8'h00;
        wait_idle();
        do_cmd(2, 0, 0, 11'b000_0001_0000);
        repeat (20) @(negedge clk);
        do_cmd(4, 0, 0, '0);
        chk(suspended && !busy, "R9 suspended state", {suspended, busy}, 2'b10);
        rd(40, a, a2);
        chk(a == model[40], "R9 array read in suspend", a, model[40]);
        rd(20, a, a2); rd(20, b, b2);
        chk(a[7] == 1'b1, "R9 poll bit in suspend", a[7], 1);
        chk(a[6] != b[6], "R4 busy toggle in suspend", b[6], !a[6]);
        do_cmd(1, 40, 8'h30, '0);
        wait_idle();
        model[40] &= 8'h30;
        chk(suspended == 1'b1, "R9 back to suspend after program", suspended, 1);
        rd(40, a, a2);
        chk(a == model[40], "R9 program in suspend", a, model[40]);
        do_cmd(1, 20, 8'h00, '0);
        chk(!busy && suspended, "R9 program to erasing sector ignored", {busy, suspended}, 2'b01);
        do_cmd(5, 0, 0, '0);
        chk(busy == 1'b1, "R10 resume restarts", busy, 1);
        wait_idle();
        for (int i = 0; i < DEPTH; i++) if (sec_of(i, 1'b0) == 4) model[i] = 8'hFF;
        check_all("R10 erase completes after resume");

        // R7 chip erase with sector 2 protected
        do_cmd(1, 6, 8'h11, '0); model[6] &= 8'h11;
        wait_idle();
        prot_mask = 11'b000_0000_0100;
        do_cmd(3, 0, 0, '0);
        wait_idle();
        for (int i = 0; i < DEPTH; i++) if (sec_of(i, 1'b0) != 2) model[i] = 8'hFF;
        check_all("R7 chip erase result");
        prot_mask = '0;

        // R11 abort by reset during erase and during suspend
        do_cmd(3, 0, 0, '0);
        repeat (10) @(negedge clk);
        rst = 1'b1; @(negedge clk);
        chk(!busy && !suspended, "R11 abort erase", {busy, suspended}, 0);
        rst = 1'b0;
        do_cmd(3, 0, 0, '0);
        do_cmd(4, 0, 0, '0);
        rst = 1'b1; @(negedge clk);
        chk(!busy && !suspended, "R11 abort suspend", {busy, suspended}, 0);
        rst = 1'b0;

        // R12 boot ordering, both instances see the same requests
        do_reset();
        do_cmd(1, 0, 8'h00, '0);   wait_idle();
        do_cmd(1, 112, 8'h00, '0); wait_idle();
        do_cmd(1, 127, 8'h00, '0); wait_idle();
        do_cmd(2, 0, 0, 11'b100_0000_0000);
        wait_idle();
        rd(112, a, a2);
        chk(a == 8'hFF, "R12 bottom boot sector 10 spans 112", a, 8'hFF);
        chk(a2 == 8'h00, "R12 top boot sector 10 excludes 112", a2, 8'h00);
        rd(127, a, a2);
        chk(a2 == 8'hFF, "R12 top boot sector 10 holds 127", a2, 8'hFF);
        rd(0, a, a2);
        chk(a == 8'h00 && a2 == 8'h00, "R12 address 0 untouched", {a, a2}, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule